// File: doc/BRIEF.md
# Skewed Randomized Tag Cache with Victim Reinsertion

This block is a tag-only cache model that hides set contention from the outside world. Its main array is divided into skews. Each skew picks a set for an address through its own key-dependent index fold, so one address has a different candidate set in every skew. A lookup probes all skews and a small fully associative victim buffer at the same time. On a miss, the address is installed into a slot chosen at random.

A line pushed out of the skewed array is kept. It is parked in the victim buffer. When the lookup port is idle, the buffer moves its lines back into the array one per cycle, each through a skew other than the one that displaced it. A line only leaves the structure when the victim buffer is full and a new displacement arrives. In that case a random buffer entry is reported on the eviction output, so the evictions seen outside resemble those of a fully associative cache with random replacement.

A re-key request loads fresh per-skew keys. It then clears the whole structure without reporting anything, and a busy flag stays high while the clear runs.

Top module: `skew_vc_cache`

## Requirements
- R1: After reset, `resp_valid`, `evict_valid` and `busy` are low and the structure is empty.
- R2: A request is accepted when `req_valid` is high while `busy` and `rekey_req` are low. Exactly one cycle later `resp_valid` is high, and `resp_hit` is 1 if the address was resident in the skewed array or the victim buffer, 0 otherwise.
- R3: A missed address is installed, so a later lookup of it hits unless it was reported on the eviction output in between.
- R4: `evict_valid` is raised only in the response cycle of a missed lookup. Displacements inside the skewed array and background reinsertion never raise it. No eviction is reported while at most VB_DEPTH addresses have been filled since reset or since the last re-key.
- R5: An evicted address is one that was resident, never the address whose miss caused the eviction. After its eviction a lookup of it misses.
- R6: The resident line count never exceeds WAYS*SETS + VB_DEPTH. An eviction happens only when every victim-buffer entry was valid.
- R7: A line that leaves the victim buffer for the array, whether by background reinsertion or by a lookup hitting it, is written into a skew different from the one it was displaced from.
- R8: A re-key request accepted while not busy raises `busy` from the next cycle for exactly SETS cycles. It invalidates every line and reports no eviction during that time.
- R9: A request presented while `busy` is high, or in the same cycle as `rekey_req`, gets no response.
- R10: After a re-key completes, the block works with the new keys: previously resident addresses miss, and refilled addresses hit.
- R11: A lookup address matches at most one array slot, and never both the array and the victim buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Line address to look up |
| resp_valid | output | 1 | Response to the request of the previous cycle |
| resp_hit | output | 1 | 1 when the looked-up line was resident |
| rekey_req | input | 1 | Re-key and flush request |
| rekey_keys | input | SKEWS*ADDR_W | New keys, skew 0 in the low bits |
| busy | output | 1 | Flush in progress; requests ignored |
| evict_valid | output | 1 | A line left the structure |
| evict_addr | output | ADDR_W | Address of the line that left |

## Verification
A wrong internal state shows up at the ports as a lost line or a phantom line. A lost line is a later lookup that misses without that address ever having been reported on the eviction output. A phantom line is a hit on an address that was reported evicted or flushed. Either one appears on the next lookup of the affected address, so the bench replays every filled address against a reference set of residents. A broken victim-buffer allocation shows itself within the first VB_DEPTH fills, as an early or unexplained eviction. A wrong flush length shows as a `busy` pulse of the wrong width.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE,
      OP_FILL,
      OP_MOVE,
      OP_REINS
   } ins_op_e;
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
   parameter int          W     = 16,
   parameter int          OUT_W = 6,
   parameter logic [15:0] SEED  = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   logic [W-1:0] state_q;
   logic         fb;

   generate
      if (W == 16) begin : g_w16
         assign fb = state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10];
      end else if (W == 32) begin : g_w32
         assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
      end else begin : g_bad_w
         $error("sc_lfsr: W must be 16 or 32");
      end
      if (OUT_W > W || OUT_W < 1) begin : g_bad_out
         $error("sc_lfsr: OUT_W out of range");
      end
      if (SEED == 16'h0) begin : g_bad_seed
         $error("sc_lfsr: SEED must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= W'(SEED);
      else        state_q <= {state_q[W-2:0], fb};
   end

   assign rnd = state_q[OUT_W-1:0];

   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0);
endmodule

// File: rtl/sc_index_fold.sv
module sc_index_fold #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int ROT    = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] key,
   output logic [IDX_W-1:0]  idx
);
   localparam int CHUNKS = (ADDR_W + IDX_W - 1) / IDX_W;

   logic [ADDR_W-1:0]       mixed;
   logic [ADDR_W-1:0]       rotated;
   logic [CHUNKS*IDX_W-1:0] padded;

   generate
      if (ROT < 0 || ROT >= ADDR_W) begin : g_bad_rot
         $error("sc_index_fold: ROT out of range");
      end
   endgenerate

   // Keyed, rotated XOR fold: cheap diffusion, not a cryptographic mapping.
   always_comb begin
      mixed   = addr ^ key;
      rotated = (mixed << ROT) | (mixed >> (ADDR_W - ROT));
      padded  = '0;
      padded[ADDR_W-1:0] = rotated;
      idx = '0;
      for (int c = 0; c < CHUNKS; c++) begin
         idx = idx ^ padded[c*IDX_W +: IDX_W];
      end
   end
endmodule

// File: rtl/sc_victim_buf.sv
module sc_victim_buf #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16,
   parameter int SKEW_W = 1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              probe_hit,
   output logic [IDX_W-1:0]  probe_idx,
   output logic [SKEW_W-1:0] probe_skew,
   output logic              head_valid,
   output logic [IDX_W-1:0]  head_idx,
   output logic [ADDR_W-1:0] head_addr,
   output logic [SKEW_W-1:0] head_skew,
   input  logic              wr_en,
   input  logic              wr_reuse,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [SKEW_W-1:0] wr_skew,
   input  logic [IDX_W-1:0]  rnd_idx,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_idx,
   output logic              evict_valid,
   output logic [ADDR_W-1:0] evict_addr
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sc_victim_buf: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [DEPTH-1:0]  vld_q;
   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [SKEW_W-1:0] skew_q [DEPTH];
   logic [DEPTH-1:0]  match_vec;
   logic              any_free;
   logic [IDX_W-1:0]  free_idx;
   logic [IDX_W-1:0]  tgt_idx;
   logic              spill;

   always_comb begin
      probe_idx  = '0;
      head_valid = 1'b0;
      head_idx   = '0;
      any_free   = 1'b0;
      free_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         match_vec[i] = vld_q[i] && (addr_q[i] == probe_addr);
         if (match_vec[i]) probe_idx = IDX_W'(i);
         if (vld_q[i]) begin
            head_valid = 1'b1;
            head_idx   = IDX_W'(i);
         end else begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
      probe_hit  = |match_vec;
      probe_skew = skew_q[probe_idx];
      head_addr  = addr_q[head_idx];
      head_skew  = skew_q[head_idx];
      tgt_idx    = wr_reuse ? wr_idx : (any_free ? free_idx : rnd_idx);
      spill      = wr_en && !wr_reuse && !any_free && !flush;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q       <= '0;
         evict_valid <= 1'b0;
         evict_addr  <= '0;
      end else begin
         evict_valid <= spill;
         if (spill) evict_addr <= addr_q[tgt_idx];
         if (flush) begin
            vld_q <= '0;
         end else begin
            if (clr_en) vld_q[clr_idx] <= 1'b0;
            if (wr_en)  vld_q[tgt_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         addr_q[tgt_idx] <= wr_addr;
         skew_q[tgt_idx] <= wr_skew;
      end
   end

   // R6
   vb_spill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> $past(&vld_q));
   // R11
   vb_single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
endmodule

// File: rtl/skew_vc_cache.sv
module skew_vc_cache
   import sc_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter int              SKEWS    = 2,
   parameter int              WAYS     = 4,
   parameter int              SETS     = 64,
   parameter int              VB_DEPTH = 16,
   parameter int              LFSR_W   = 16,
   parameter logic [ADDR_W-1:0] KEY_SEED = 32'h9E3779B9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    resp_valid,
   output logic                    resp_hit,
   input  logic                    rekey_req,
   input  logic [SKEWS*ADDR_W-1:0] rekey_keys,
   output logic                    busy,
   output logic                    evict_valid,
   output logic [ADDR_W-1:0]       evict_addr
);
   localparam int WPS    = WAYS / SKEWS;
   localparam int SET_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WPS);
   localparam int SKEW_W = $clog2(SKEWS);
   localparam int VB_W   = $clog2(VB_DEPTH);
   localparam int RND_W  = SKEW_W + WAY_W + VB_W;
   localparam int SLOTS  = SKEWS * WPS;

   generate
      if (SKEWS < 2 || (SKEWS & (SKEWS - 1)) != 0) begin : g_bad_skews
         $error("skew_vc_cache: SKEWS must be a power of two >= 2");
      end
      if (WPS < 2 || (WPS & (WPS - 1)) != 0 || WPS * SKEWS != WAYS) begin : g_bad_ways
         $error("skew_vc_cache: WAYS must split into a power of two >= 2 per skew");
      end
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("skew_vc_cache: SETS must be a power of two >= 2");
      end
      if (RND_W > LFSR_W) begin : g_bad_rnd
         $error("skew_vc_cache: LFSR too narrow for random fields");
      end
   endgenerate

   // storage and control state
   logic [ADDR_W-1:0] tag_q [SKEWS][WPS][SETS];
   logic              vld_q [SKEWS][WPS][SETS];
   logic [ADDR_W-1:0] key_q [SKEWS];
   logic              busy_q;
   logic [SET_W-1:0]  flush_cnt;

   // victim buffer interface
   logic              vb_hit, vb_head_valid;
   logic [VB_W-1:0]   vb_hit_idx, vb_head_idx;
   logic [SKEW_W-1:0] vb_hit_skew, vb_head_skew;
   logic [ADDR_W-1:0] vb_head_addr;

   // per-skew indices
   logic [SET_W-1:0]  lk_idx [SKEWS];
   logic [SET_W-1:0]  ri_idx [SKEWS];

   genvar gs;
   generate
      for (gs = 0; gs < SKEWS; gs++) begin : g_skew
         localparam int ROT_S = (gs * (SET_W / 2 + 1)) % ADDR_W;
         sc_index_fold #(.ADDR_W(ADDR_W), .IDX_W(SET_W), .ROT(ROT_S)) u_lookup_idx (
            .addr (req_addr),
            .key  (key_q[gs]),
            .idx  (lk_idx[gs])
         );
         sc_index_fold #(.ADDR_W(ADDR_W), .IDX_W(SET_W), .ROT(ROT_S)) u_reins_idx (
            .addr (vb_head_addr),
            .key  (key_q[gs]),
            .idx  (ri_idx[gs])
         );
      end
   endgenerate

   // random fields
   logic [RND_W-1:0]  rnd;
   logic [SKEW_W-1:0] rnd_sk;
   logic [WAY_W-1:0]  rnd_way;
   logic [VB_W-1:0]   rnd_vb;

   sc_lfsr #(.W(LFSR_W), .OUT_W(RND_W)) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   assign rnd_sk  = rnd[SKEW_W-1:0];
   assign rnd_way = rnd[SKEW_W +: WAY_W];
   assign rnd_vb  = rnd[RND_W-1 -: VB_W];

   // probe
   logic [SLOTS-1:0] hit_vec;
   logic             arr_hit;

   always_comb begin
      for (int s = 0; s < SKEWS; s++) begin
         for (int w = 0; w < WPS; w++) begin
            hit_vec[s*WPS + w] = vld_q[s][w][lk_idx[s]] &&
                                 (tag_q[s][w][lk_idx[s]] == req_addr);
         end
      end
      arr_hit = |hit_vec;
   end

   // insertion control
   logic              accept, start;
   ins_op_e           op;
   logic [ADDR_W-1:0] ins_addr;
   logic [SKEW_W-1:0] origin;
   logic [VB_W-1:0]   mv_idx;
   logic [SKEW_W-1:0] tgt;
   logic [SET_W-1:0]  tgt_set;
   logic              disp_vld;
   logic [ADDR_W-1:0] disp_addr;
   int unsigned       tsum;

   assign accept = req_valid && !busy_q && !rekey_req;
   assign start  = rekey_req && !busy_q;

   always_comb begin
      op       = OP_IDLE;
      ins_addr = req_addr;
      origin   = '0;
      mv_idx   = '0;
      if (accept) begin
         if (!arr_hit && vb_hit) begin
            op     = OP_MOVE;
            origin = vb_hit_skew;
            mv_idx = vb_hit_idx;
         end else if (!arr_hit) begin
            op = OP_FILL;
         end
      end else if (!busy_q && !rekey_req && !req_valid && vb_head_valid) begin
         op       = OP_REINS;
         ins_addr = vb_head_addr;
         origin   = vb_head_skew;
         mv_idx   = vb_head_idx;
      end
      tsum = (32'(origin) + 32'd1 + (32'(rnd_sk) % (SKEWS - 1))) % SKEWS;
      tgt  = (op == OP_FILL) ? rnd_sk : SKEW_W'(tsum);
      tgt_set   = (op == OP_REINS) ? ri_idx[tgt] : lk_idx[tgt];
      disp_vld  = vld_q[tgt][rnd_way][tgt_set];
      disp_addr = tag_q[tgt][rnd_way][tgt_set];
   end

   logic vb_wr_en, vb_reuse, vb_clr_en;
   assign vb_reuse  = (op == OP_MOVE) || (op == OP_REINS);
   assign vb_wr_en  = (op != OP_IDLE) && disp_vld;
   assign vb_clr_en = vb_reuse && !disp_vld;

   sc_victim_buf #(.ADDR_W(ADDR_W), .DEPTH(VB_DEPTH), .SKEW_W(SKEW_W)) u_vb (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (start),
      .probe_addr  (req_addr),
      .probe_hit   (vb_hit),
      .probe_idx   (vb_hit_idx),
      .probe_skew  (vb_hit_skew),
      .head_valid  (vb_head_valid),
      .head_idx    (vb_head_idx),
      .head_addr   (vb_head_addr),
      .head_skew   (vb_head_skew),
      .wr_en       (vb_wr_en),
      .wr_reuse    (vb_reuse),
      .wr_idx      (mv_idx),
      .wr_addr     (disp_addr),
      .wr_skew     (tgt),
      .rnd_idx     (rnd_vb),
      .clr_en      (vb_clr_en),
      .clr_idx     (mv_idx),
      .evict_valid (evict_valid),
      .evict_addr  (evict_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SKEWS; s++) begin
            key_q[s] <= KEY_SEED + ADDR_W'(s) * ADDR_W'(32'h6A09E667);
            for (int w = 0; w < WPS; w++) begin
               for (int e = 0; e < SETS; e++) vld_q[s][w][e] <= 1'b0;
            end
         end
         busy_q     <= 1'b0;
         flush_cnt  <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
      end else begin
         resp_valid <= accept;
         resp_hit   <= accept && (arr_hit || vb_hit);
         if (start) begin
            busy_q    <= 1'b1;
            flush_cnt <= '0;
            for (int s = 0; s < SKEWS; s++) key_q[s] <= rekey_keys[s*ADDR_W +: ADDR_W];
         end else if (busy_q) begin
            for (int s = 0; s < SKEWS; s++) begin
               for (int w = 0; w < WPS; w++) vld_q[s][w][flush_cnt] <= 1'b0;
            end
            if (flush_cnt == SET_W'(SETS - 1)) busy_q <= 1'b0;
            flush_cnt <= flush_cnt + 1'b1;
         end else if (op != OP_IDLE) begin
            vld_q[tgt][rnd_way][tgt_set] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (op != OP_IDLE) tag_q[tgt][rnd_way][tgt_set] <= ins_addr;
   end

   assign busy = busy_q;

   // R2
   resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(req_valid && !busy_q && !rekey_req));
   // R9
   ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && req_valid) |=> !resp_valid);
   // R4
   evict_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> $past(op == OP_FILL));
   // R8
   quiet_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !evict_valid);
   // R8
   flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(flush_cnt) == SET_W'(SETS - 1));
   // R7
   other_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MOVE || op == OP_REINS) |-> tgt != origin);
   // R11
   unique_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> ($onehot0(hit_vec) && !(arr_hit && vb_hit)));
endmodule

// File: tb/tb_skew_vc_cache.sv
`timescale 1ns/1ps
module tb_skew_vc_cache;
   localparam int AW  = 32;
   localparam int SK  = 2;
   localparam int WY  = 4;
   localparam int ST  = 64;
   localparam int VD  = 16;
   localparam int CAP = WY * ST + VD;
   localparam int NSWEEP = 600;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [AW-1:0]    req_addr = '0;
   logic             rekey_req = 1'b0;
   logic [SK*AW-1:0] rekey_keys = 64'h5BD1E995_C2B2AE35;
   logic             resp_valid, resp_hit, busy, evict_valid;
   logic [AW-1:0]    evict_addr;

   skew_vc_cache dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .resp_valid  (resp_valid),
      .resp_hit    (resp_hit),
      .rekey_req   (rekey_req),
      .rekey_keys  (rekey_keys),
      .busy        (busy),
      .evict_valid (evict_valid),
      .evict_addr  (evict_addr)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int n_evict = 0;
   bit done = 1'b0;
   bit resident [logic [AW-1:0]];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic access(input logic [AW-1:0] a, input string req);
      bit exp_hit;
      exp_hit = resident.exists(a);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      check(resp_valid == 1'b1, "R2", "resp_valid", 64'(resp_valid), 64'd1);
      check(resp_hit == exp_hit, req, "resp_hit", 64'(resp_hit), 64'(exp_hit));
      if (!exp_hit) resident[a] = 1'b1;
      if (evict_valid) begin
         n_evict++;
         check(!exp_hit, "R4", "evict after hit", 64'(evict_valid), 64'd0);
         check(resident.exists(evict_addr) && evict_addr != a, "R5", "evict_addr",
               64'(evict_addr), 64'(a));
         if (resident.exists(evict_addr)) resident.delete(evict_addr);
      end
      check(resident.num() <= CAP, "R6", "resident count", 64'(resident.num()), 64'(CAP));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(!evict_valid && !resp_valid, "R4", "idle outputs",
               64'({resp_valid, evict_valid}), 64'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int ev0;
      int busy_cycles;
      repeat (3) @(negedge clk);
      // R1
      check(!resp_valid, "R1", "resp_valid", 64'(resp_valid), 64'd0);
      check(!evict_valid, "R1", "evict_valid", 64'(evict_valid), 64'd0);
      check(!busy, "R1", "busy", 64'(busy), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3, R4: within victim capacity nothing may leave
      for (int i = 0; i < VD; i++) access(32'h0000_1000 + 32'(i) * 32'd64, "R3");
      idle(8);
      for (int i = 0; i < VD; i++) access(32'h0000_1000 + 32'(i) * 32'd64, "R3");
      check(n_evict == 0, "R4", "evictions within capacity", 64'(n_evict), 64'd0);

      // R3, R5, R6: sweep well past total capacity
      for (int i = 0; i < NSWEEP; i++) begin
         access(32'h0004_0000 + 32'(i) * 32'd37, "R3");
         if (i % 4 == 0) idle(1);
      end
      for (int i = NSWEEP - 1; i >= 0; i--) begin
         access(32'h0004_0000 + 32'(i) * 32'd37, "R5");
         if (i % 5 == 0) idle(2);
      end
      check(n_evict > NSWEEP - CAP, "R6", "eviction count", 64'(n_evict), 64'(NSWEEP - CAP));

      // R8, R9: re-key with a simultaneous request
      rekey_req = 1'b1;
      req_valid = 1'b1;
      req_addr  = 32'h0004_0000;
      @(negedge clk);
      rekey_req = 1'b0;
      check(!resp_valid, "R9", "resp with rekey", 64'(resp_valid), 64'd0);
      check(busy, "R8", "busy raised", 64'(busy), 64'd1);
      busy_cycles = 1;
      for (int k = 0; k < 200; k++) begin
         req_valid = 1'b1;
         req_addr  = 32'h0004_0000 + 32'(k);
         @(negedge clk);
         check(!resp_valid, "R9", "resp while busy", 64'(resp_valid), 64'd0);
         check(!evict_valid, "R8", "evict while busy", 64'(evict_valid), 64'd0);
         if (busy) busy_cycles++;
         else break;
      end
      req_valid = 1'b0;
      check(busy_cycles == ST, "R8", "busy length", 64'(busy_cycles), 64'(ST));
      resident.delete();

      // R8, R10: everything gone, new keys usable
      ev0 = n_evict;
      for (int i = 0; i < VD; i++) access(32'h0004_0000 + 32'(i) * 32'd37, "R8");
      idle(6);
      for (int i = 0; i < VD; i++) access(32'h0004_0000 + 32'(i) * 32'd37, "R10");
      check(n_evict == ev0, "R4", "evictions after flush", 64'(n_evict - ev0), 64'd0);

      summary();
   end
endmodule